// File: doc/BRIEF.md
# Interlocked Debug Register Target

This block is a small register file that answers single transactions on a debug-module bus. The bus runs in the system clock domain and uses a four-phase request/acknowledge handshake. The master raises `req` together with the address, the write data and the direction flag. The target takes the transaction on the first clock where it sees `req` high while it is idle, and then raises `ack`. It keeps `ack` and the read data fixed until the master lowers `req`, and it drops `ack` one clock after that.

A master may stall indefinitely with `req` held high, for example when its own clock has stopped. The target performs each transaction exactly once, on the cycle it accepts it. It does not act on any change of address, data or direction that arrives later in the same request. Registers sit at addresses `0` to `NUM_REGS-1`. A read from any other address returns zero. A write to any other address changes nothing but is still acknowledged.

Top module: `dbgt_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears `ack`, `rdata` and every register to zero.
- R2: When the target is idle and samples `req` high, `ack` is high after that same clock edge, exactly one clock after `req` was first seen.
- R3: Once `ack` is high it stays high for as long as `req` is sampled high, however many cycles that is.
- R4: `ack` goes low on the clock edge after `req` is first sampled low.
- R5: While `ack` is high, `rdata` does not change.
- R6: A request with `wr`=1 stores `wdata` into register `addr` when `addr` < `NUM_REGS`. A later read of that address returns the stored value.
- R7: A write changes the register file only once per request, using the `addr` and `wdata` sampled on the accepting edge. Changes to those inputs while `req` stays high have no effect.
- R8: Reads from an address at or above `NUM_REGS` return zero. Writes to such an address leave every register unchanged but are still acknowledged.
- R9: A request with `wr`=0 loads `rdata` with the register selected by the `addr` sampled on the accepting edge. `rdata` keeps that value until the next read is accepted.
- R10: If `req` is high when `rst_n` is released, the target accepts it as a new request on the first clock edge with `rst_n` high.
- R11: A new request raised one clock after `ack` was observed low is accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Request from the bus master |
| wr | input | 1 | 1 = write, 0 = read; valid with `req` |
| addr | input | ADDR_W (8) | Register address; valid with `req` |
| wdata | input | DATA_W (32) | Write data; valid with `req` |
| ack | output | 1 | Acknowledge, held until `req` falls |
| rdata | output | DATA_W (32) | Read data, stable while `ack` is high |

## Verification
The embedded assertions check the handshake on every cycle: `ack` follows an idle `req` by one clock, holds while `req` holds, and falls one clock after `req` falls. They also check that `rdata` stays still while `ack` is high and that a register write strobe never lasts two cycles. Only the directed scenarios can show what the data means. They cover read-back of written values, single-write behaviour when the inputs change during a long stall, silence of unmapped addresses, and acceptance of a request held across reset release, all judged against a model kept in the bench.

// File: rtl/dbgt_pkg.sv
// Package: shared types for the debug register target.
// Assumes: nothing beyond a single synchronous clock domain.
package dbgt_pkg;

    // Handshake phase: waiting for a request, or holding ack for one.
    typedef enum logic [0:0] {
        HS_IDLE = 1'b0,
        HS_BUSY = 1'b1
    } hs_state_e;

endpackage : dbgt_pkg

// File: rtl/dbgt_handshake.sv
// Module: dbgt_handshake
// Runs the four-phase request/acknowledge sequence. It emits a one-cycle
// accept pulse when an idle target sees req high. It then holds ack
// until req is sampled low.
// Assumes: req is synchronous to clk; the reset is synchronous and active low.
module dbgt_handshake
    import dbgt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic ack,
    output logic accept
);

    hs_state_e state_q;
    hs_state_e state_d;

    // Next-state choice for the handshake phase.
    always_comb begin
        state_d = state_q;
        case (state_q)
            HS_IDLE: if (req)  state_d = HS_BUSY;
            HS_BUSY: if (!req) state_d = HS_IDLE;
            default:           state_d = HS_IDLE;
        endcase
    end

    // Phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    assign ack    = (state_q == HS_BUSY);
    assign accept = (state_q == HS_IDLE) && req;

    // R2: an idle target answers a request on the next edge.
    a_r2_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && req) |=> ack);

    // R3: ack holds while the master keeps req high.
    a_r3_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req) |=> ack);

    // R4: ack falls one edge after req is seen low.
    a_r4_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !req) |=> !ack);

endmodule : dbgt_handshake

// File: rtl/dbgt_reg_bank.sv
// Module: dbgt_reg_bank
// Holds NUM_REGS data registers at addresses 0..NUM_REGS-1. It writes one
// register per strobe and returns zero for reads outside the mapped range.
// Assumes: NUM_REGS <= 2**ADDR_W; wr_en lasts a single cycle per request.
module dbgt_reg_bank #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] regs_q [NUM_REGS];

    generate
        for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
            // One storage word: cleared on reset, loaded when selected.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_q[gi] <= '0;
                else if (wr_en && (wr_addr == ADDR_W'(gi)))
                    regs_q[gi] <= wr_data;
            end
        end
    endgenerate

    // Read selection; unmapped addresses give zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_data = regs_q[i];
        end
    end

endmodule : dbgt_reg_bank

// File: rtl/dbgt_rd_hold.sv
// Module: dbgt_rd_hold
// Captures read data on an accepted read and keeps it until the next one,
// so the bus sees a steady value for the whole acknowledge phase.
// Assumes: load pulses only while ack is low (at acceptance).
module dbgt_rd_hold #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              ack,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    // Read-data holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= din;
    end

    // R5: read data stays still across consecutive acknowledged cycles.
    a_r5_rdata_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (!ack || $stable(dout)));

endmodule : dbgt_rd_hold

// File: rtl/dbgt_top.sv
// Module: dbgt_top
// Debug-bus register target. The handshake controller accepts each request
// once. The register bank stores writes, and the hold stage freezes read
// data while ack is high.
// Assumes: bus inputs are synchronous to clk and valid whenever req is high.
module dbgt_top #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);

    logic              accept;
    logic              wr_en;
    logic              rd_load;
    logic [DATA_W-1:0] bank_rd;

    dbgt_handshake u_hs (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .ack    (ack),
        .accept (accept)
    );

    assign wr_en   = accept && wr;
    assign rd_load = accept && !wr;

    dbgt_reg_bank #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (addr),
        .wr_data (wdata),
        .rd_addr (addr),
        .rd_data (bank_rd)
    );

    dbgt_rd_hold #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rd_load),
        .ack   (ack),
        .din   (bank_rd),
        .dout  (rdata)
    );

    // R7: a write strobe never lasts two cycles and is always followed by ack.
    a_r7_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!wr_en && ack));

endmodule : dbgt_top

// File: tb/dbgt_top_tb.sv
module dbgt_top_tb;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NR = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          ack;
    logic [DW-1:0] rdata;

    int checks = 0;
    int failures = 0;
    logic [DW-1:0] model [NR];

    always #10 clk = ~clk;

    dbgt_top #(.ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NR)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr),
        .addr(addr), .wdata(wdata), .ack(ack), .rdata(rdata)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // One full transaction; drives on falling edges and checks the handshake.
    task automatic xfer(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int hold, output logic [DW-1:0] rd);
        logic [DW-1:0] first;
        @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = d;
        chk("R2 ack low before edge", DW'(ack), '0);
        @(negedge clk);
        chk("R2 ack one clock after req", DW'(ack), 1);
        first = rdata;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R3 ack held", DW'(ack), 1);
            chk("R5 rdata stable", rdata, first);
        end
        req = 1'b0;
        @(negedge clk);
        chk("R4 ack dropped", DW'(ack), '0);
        rd = first;
    endtask

    task automatic test_reset();
        logic [DW-1:0] v;
        @(negedge clk);
        chk("R1 ack after reset", DW'(ack), '0);
        chk("R1 rdata after reset", rdata, '0);
        for (int i = 0; i < NR; i++) begin
            xfer(1'b0, AW'(i), '0, 0, v);
            chk("R1 register cleared", v, '0);
        end
    endtask

    task automatic test_write_read();
        logic [DW-1:0] v;
        for (int i = 0; i < NR; i++) begin
            model[i] = 32'hA5000000 ^ (32'h01010101 * (i + 1));
            xfer(1'b1, AW'(i), model[i], i % 3, v);
        end
        for (int i = NR - 1; i >= 0; i--) begin
            xfer(1'b0, AW'(i), '0, 2, v);
            chk("R6 R9 read back", v, model[i]);
        end
    endtask

    task automatic test_stall_write();
        logic [DW-1:0] v;
        @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = 8'd2; wdata = 32'h1234_5678;
        @(negedge clk);
        chk("R2 stall write ack", DW'(ack), 1);
        wdata = 32'hDEAD_BEEF; addr = 8'd3;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk("R3 long stall ack", DW'(ack), 1);
        end
        req = 1'b0;
        @(negedge clk);
        chk("R4 stall write release", DW'(ack), '0);
        model[2] = 32'h1234_5678;
        xfer(1'b0, 8'd2, '0, 0, v);
        chk("R7 captured data written once", v, model[2]);
        xfer(1'b0, 8'd3, '0, 0, v);
        chk("R7 late address ignored", v, model[3]);
    endtask

    task automatic test_stall_read();
        logic [DW-1:0] first;
        @(negedge clk);
        req = 1'b1; wr = 1'b0; addr = 8'd5;
        @(negedge clk);
        first = rdata;
        chk("R9 read value", first, model[5]);
        addr = 8'd6; wr = 1'b1; wdata = 32'hFFFF_0000;
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            chk("R5 rdata stable on stalled read", rdata, model[5]);
        end
        req = 1'b0; wr = 1'b0;
        @(negedge clk);
        chk("R4 read release", DW'(ack), '0);
        chk("R9 rdata kept after ack", rdata, model[5]);
    endtask

    task automatic test_unmapped();
        logic [DW-1:0] v;
        xfer(1'b1, 8'd200, 32'hCAFE_F00D, 3, v);
        xfer(1'b1, AW'(NR), 32'h7777_7777, 0, v);
        xfer(1'b0, 8'd200, '0, 1, v);
        chk("R8 unmapped read zero", v, '0);
        xfer(1'b0, 8'hFF, '0, 0, v);
        chk("R8 top address read zero", v, '0);
        for (int i = 0; i < NR; i++) begin
            xfer(1'b0, AW'(i), '0, 0, v);
            chk("R8 registers untouched", v, model[i]);
        end
    endtask

    task automatic test_back_to_back();
        logic [DW-1:0] v;
        model[0] = 32'h0BAD_CAFE;
        xfer(1'b1, 8'd0, model[0], 0, v);
        // Next request raised one clock after ack seen low (R11).
        xfer(1'b0, 8'd0, '0, 0, v);
        chk("R11 back-to-back read", v, model[0]);
    endtask

    task automatic test_reset_with_req();
        logic [DW-1:0] v;
        @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = 8'd1; wdata = 32'h5555_AAAA;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 ack low in reset", DW'(ack), '0);
        chk("R1 rdata cleared in reset", rdata, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 request accepted after reset", DW'(ack), 1);
        req = 1'b0;
        @(negedge clk);
        chk("R4 release after reset request", DW'(ack), '0);
        for (int i = 0; i < NR; i++) model[i] = '0;
        model[1] = 32'h5555_AAAA;
        xfer(1'b0, 8'd1, '0, 0, v);
        chk("R10 write performed", v, model[1]);
        xfer(1'b0, 8'd2, '0, 0, v);
        chk("R1 other registers cleared", v, '0);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        for (int i = 0; i < NR; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_write_read();
        test_stall_write();
        test_stall_read();
        test_unmapped();
        test_back_to_back();
        test_reset_with_req();
        repeat (2) @(negedge clk);
        summary();
    end

endmodule : dbgt_top_tb